// File: doc/BRIEF.md
# Stuck Bus Detector and Recovery Sequencer

This block watches the two lines of a two-wire serial bus on the card side of a bus buffer. It times how long each line stays low. If either line is held low past a long limit, the bus is treated as stuck and a fault is raised. In the automatic mode, the block also asks the connection bridge to split the two bus segments. It then tries to free the card side. To do this it clocks SCL a bounded number of times at a fixed rate and finishes with a stop condition.

In the manual mode, the block only flags the fault. Software or a master can clear the fault at any time by dropping the enable input low and raising it again. Line levels arrive already synchronised to the block clock. The pull outputs drive open-drain pull-down stages. Every time value is given in microseconds or hertz and converted to clock counts from a clock-frequency parameter.

Top module: `stuck_bus_guard`

## Requirements
- R1: After reset, `fault`, `disc_req`, `scl_pull` and `sda_pull` are all 0, and `ready` equals `en`.
- R2: SDA is timed on its own. If SDA is sampled low on STUCK_CYC consecutive clock edges, `fault` rises one edge later and not earlier. A single high sample restarts the count from zero.
- R3: SCL has a separate timer. A short low on SDA during an SCL timeout does not change when the SCL fault appears.
- R4: With `auto_disc_en` = 1, `disc_req` rises at the same edge as `fault`, and `ready` falls to 0 while `disc_req` is 1.
- R5: Recovery clocking holds `scl_pull` at 1 for HALF_CYC cycles and then at 0 for HALF_CYC cycles per pulse. The first pulse starts at the fault edge, and there are never more than MAX_PULSES pulses.
- R6: When the stuck line is seen released during clocking, `fault` clears at the next edge and clocking stops. For SCL, released means high while the block itself is not pulling it.
- R7: After clocking ends, `sda_pull` = 1 and `scl_pull` = 0 for exactly STOP_CYC cycles. Then `sda_pull` returns to 0, and `disc_req` drops if the bus was freed.
- R8: If the line is still stuck after MAX_PULSES pulses, the stop is still generated. `fault` and `disc_req` then stay 1 until both lines are seen high.
- R9: With `auto_disc_en` = 0, a stuck line sets `fault` only. `disc_req`, `scl_pull` and `sda_pull` stay 0, and `fault` clears once both lines are high.
- R10: While `en` = 0, all outputs are 0 from the next edge on and both timers are cleared. After `en` returns to 1, a line that is still stuck needs a full new STUCK_CYC before the fault comes back.
- R11: If the release is seen in the same cycle that the last pulse completes, the release wins and `fault` is cleared as the stop begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable; a low-then-high pulse clears fault and timers |
| auto_disc_en | input | 1 | 1 = disconnect and recover on a fault; 0 = flag only |
| sda_in | input | 1 | Sampled level of the card-side data line |
| scl_in | input | 1 | Sampled level of the card-side clock line |
| fault | output | 1 | Stuck bus flag (1 = fault) |
| ready | output | 1 | Segments may be joined (enabled and no disconnect request) |
| disc_req | output | 1 | Request to the bridge to split the segments |
| scl_pull | output | 1 | Pull card-side SCL low |
| sda_pull | output | 1 | Pull card-side SDA low |

## Verification
Two events can land in the same cycle: the stuck line being released, and the final recovery pulse completing. Both lead into the stop phase, but they differ in whether the fault is kept. The bench counts edges from the fault edge and lets SDA go high in the last cycle of the final pulse. It expects `fault` to read 0 as soon as `sda_pull` rises. In a second run the release comes one cycle later. There the bench expects `fault` to stay 1 through the whole stop and to clear only in the hold phase that follows.

// File: rtl/stuck_pkg.sv
package stuck_pkg;

    typedef enum logic [2:0] {
        SQ_MON,    // lines are being timed
        SQ_FLAG,   // fault flagged, manual mode
        SQ_CLOCK,  // recovery pulses on SCL
        SQ_STOP,   // stop condition: SDA held low, SCL released
        SQ_HOLD    // recovery done, line still stuck
    } seq_state_e;

    localparam int unsigned NUM_LINES = 2;
    localparam int unsigned LINE_SDA  = 0;
    localparam int unsigned LINE_SCL  = 1;

endpackage

// File: rtl/stuck_low_timer.sv
module stuck_low_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic line_i,
    output logic stuck_o
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || line_i) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_W'(LIMIT)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign stuck_o = (cnt_q == CNT_W'(LIMIT));

    // R2
    stuck_only_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stuck_o) |-> $past(run && !line_i));

endmodule

// File: rtl/recovery_seq.sv
module recovery_seq
    import stuck_pkg::*;
#(
    parameter int unsigned HALF_CYC   = 10,
    parameter int unsigned MAX_PULSES = 16,
    parameter int unsigned STOP_CYC   = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic auto_en,
    input  logic sda_in,
    input  logic scl_in,
    input  logic sda_stuck,
    input  logic scl_stuck,
    output logic timers_run,
    output logic fault_o,
    output logic disc_o,
    output logic scl_pull_o,
    output logic sda_pull_o
);
    localparam int unsigned HALF_W  = $clog2(HALF_CYC + 1);
    localparam int unsigned PULSE_W = $clog2(MAX_PULSES + 1);
    localparam int unsigned STOP_W  = $clog2(STOP_CYC + 1);

    typedef struct packed {
        seq_state_e         st;
        logic               fault;
        logic               disc;
        logic               scl_pull;
        logic               sda_pull;
        logic               stk_sda;
        logic               stk_scl;
        logic [HALF_W-1:0]  half;
        logic [PULSE_W-1:0] pulses;
        logic [STOP_W-1:0]  stop;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        st: SQ_MON, fault: 1'b0, disc: 1'b0, scl_pull: 1'b0, sda_pull: 1'b0,
        stk_sda: 1'b0, stk_scl: 1'b0, half: '0, pulses: '0, stop: '0};

    seq_t q, d;
    logic released;
    logic start_stop;

    always_comb begin
        d          = q;
        start_stop = 1'b0;
        released   = (!q.stk_sda || sda_in) &&
                     (!q.stk_scl || (scl_in && !q.scl_pull));
        if (!en) begin
            d = SEQ_RESET;
        end else begin
            unique case (q.st)
                SQ_MON: begin
                    if (sda_stuck || scl_stuck) begin
                        d.fault   = 1'b1;
                        d.stk_sda = sda_stuck;
                        d.stk_scl = scl_stuck;
                        if (auto_en) begin
                            d.st       = SQ_CLOCK;
                            d.disc     = 1'b1;
                            d.scl_pull = 1'b1;
                            d.half     = '0;
                            d.pulses   = '0;
                        end else begin
                            d.st = SQ_FLAG;
                        end
                    end
                end
                SQ_FLAG: begin
                    if (sda_in && scl_in) begin
                        d.st    = SQ_MON;
                        d.fault = 1'b0;
                    end
                end
                SQ_CLOCK: begin
                    if (released) begin
                        d.fault    = 1'b0;
                        start_stop = 1'b1;
                    end else if (q.half == HALF_W'(HALF_CYC - 1)) begin
                        d.half = '0;
                        if (q.scl_pull) begin
                            d.scl_pull = 1'b0;
                        end else if (q.pulses == PULSE_W'(MAX_PULSES - 1)) begin
                            start_stop = 1'b1;
                        end else begin
                            d.pulses   = q.pulses + 1'b1;
                            d.scl_pull = 1'b1;
                        end
                    end else begin
                        d.half = q.half + 1'b1;
                    end
                    if (start_stop) begin
                        d.st       = SQ_STOP;
                        d.scl_pull = 1'b0;
                        d.sda_pull = 1'b1;
                        d.stop     = '0;
                    end
                end
                SQ_STOP: begin
                    if (q.stop == STOP_W'(STOP_CYC - 1)) begin
                        d.sda_pull = 1'b0;
                        d.disc     = q.fault;
                        d.st       = q.fault ? SQ_HOLD : SQ_MON;
                    end else begin
                        d.stop = q.stop + 1'b1;
                    end
                end
                SQ_HOLD: begin
                    if (sda_in && scl_in) begin
                        d.st    = SQ_MON;
                        d.fault = 1'b0;
                        d.disc  = 1'b0;
                    end
                end
                default: d = SEQ_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RESET;
        else        q <= d;
    end

    assign timers_run = en && (q.st == SQ_MON);
    assign fault_o    = q.fault;
    assign disc_o     = q.disc;
    assign scl_pull_o = q.scl_pull;
    assign sda_pull_o = q.sda_pull;

    // R4
    disc_with_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disc_o) |-> fault_o);

    // R9
    disc_needs_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disc_o) |-> $past(auto_en));

    // R10
    enable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!fault_o && !disc_o && !scl_pull_o && !sda_pull_o));

    // R7
    pulls_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_pull_o && sda_pull_o));

    // R5
    clock_only_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull_o |-> disc_o);

endmodule

// File: rtl/stuck_bus_guard.sv
module stuck_bus_guard
    import stuck_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ   = 50_000_000,
    parameter int unsigned STUCK_TIME_US = 30_000,
    parameter int unsigned RECOV_CLK_HZ  = 8_500,
    parameter int unsigned STOP_HOLD_US  = 125,
    parameter int unsigned MAX_PULSES    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic auto_disc_en,
    input  logic sda_in,
    input  logic scl_in,
    output logic fault,
    output logic ready,
    output logic disc_req,
    output logic scl_pull,
    output logic sda_pull
);
    localparam int unsigned CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
    localparam int unsigned STUCK_CYC  = CYC_PER_US * STUCK_TIME_US;
    localparam int unsigned HALF_CYC   = CLK_FREQ_HZ / (2 * RECOV_CLK_HZ);
    localparam int unsigned STOP_CYC   = CYC_PER_US * STOP_HOLD_US;

    logic [NUM_LINES-1:0] line_lvl;
    logic [NUM_LINES-1:0] line_stuck;
    logic                 timers_run;

    assign line_lvl[LINE_SDA] = sda_in;
    assign line_lvl[LINE_SCL] = scl_in;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_timer
        stuck_low_timer #(.LIMIT(STUCK_CYC)) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (timers_run),
            .line_i  (line_lvl[g]),
            .stuck_o (line_stuck[g])
        );
    end

    recovery_seq #(
        .HALF_CYC   (HALF_CYC),
        .MAX_PULSES (MAX_PULSES),
        .STOP_CYC   (STOP_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .auto_en    (auto_disc_en),
        .sda_in     (sda_in),
        .scl_in     (scl_in),
        .sda_stuck  (line_stuck[LINE_SDA]),
        .scl_stuck  (line_stuck[LINE_SCL]),
        .timers_run (timers_run),
        .fault_o    (fault),
        .disc_o     (disc_req),
        .scl_pull_o (scl_pull),
        .sda_pull_o (sda_pull)
    );

    assign ready = en && !disc_req;

endmodule

// File: tb/stuck_bus_guard_test.sv
module stuck_bus_guard_test;
    localparam int S = 200;   // STUCK_CYC at 1 cycle per us
    localparam int H = 10;    // HALF_CYC
    localparam int P = 16;    // MAX_PULSES
    localparam int T = 30;    // STOP_CYC

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic auto_en = 1'b1;
    logic sda_hold = 1'b0;
    logic scl_hold = 1'b0;
    logic sda_in, scl_in;
    logic fault, ready, disc_req, scl_pull, sda_pull;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    assign sda_in = ~(sda_pull | sda_hold);
    assign scl_in = ~(scl_pull | scl_hold);

    stuck_bus_guard #(
        .CLK_FREQ_HZ(1_000_000), .STUCK_TIME_US(S), .RECOV_CLK_HZ(50_000),
        .STOP_HOLD_US(T), .MAX_PULSES(P)
    ) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .auto_disc_en(auto_en),
        .sda_in(sda_in), .scl_in(scl_in), .fault(fault), .ready(ready),
        .disc_req(disc_req), .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        sda_hold = 1'b0; scl_hold = 1'b0; en = 1'b1;
        tick(3);
    endtask

    task automatic t_reset();
        check("R1 fault", fault, 0);
        check("R1 disc_req", disc_req, 0);
        check("R1 pulls", {scl_pull, sda_pull}, 0);
        check("R1 ready", ready, 1);
    endtask

    task automatic t_sda_manual();
        auto_en = 1'b0;
        sda_hold = 1'b1; tick(50);
        sda_hold = 1'b0; tick(1);          // R2 restart
        sda_hold = 1'b1; tick(S);
        check("R2 no fault at limit", fault, 0);
        tick(1);
        check("R2 fault one edge later", fault, 1);
        tick(20);
        check("R9 no disc", disc_req, 0);
        check("R9 no pulls", {scl_pull, sda_pull}, 0);
        check("R9 ready kept", ready, 1);
        sda_hold = 1'b0; tick(1);
        check("R9 fault cleared", fault, 0);
        auto_en = 1'b1;
        settle();
    endtask

    task automatic t_scl_exhaust();
        int rises = 0; int lows = 0; int prev = 0;
        scl_hold = 1'b1; tick(100);
        sda_hold = 1'b1; tick(20);
        sda_hold = 1'b0; tick(S - 120);
        check("R3 no fault at limit", fault, 0);
        tick(1);
        check("R3 scl fault", fault, 1);
        check("R4 disc_req", disc_req, 1);
        check("R4 ready low", ready, 0);
        for (int i = 0; i < 2 * H * P + 5; i++) begin
            if (scl_pull && prev == 0) rises++;
            if (scl_pull) lows++;
            if (i == H - 1) check("R5 first low phase", scl_pull, 1);
            if (i == H)     check("R5 first high phase", scl_pull, 0);
            prev = scl_pull;
            tick(1);
        end
        check("R5 pulse count", rises, P);
        check("R5 low cycles", lows, H * P);
        check("R8 stop sda_pull", sda_pull, 1);
        check("R8 fault kept in stop", fault, 1);
        tick(T - 5);
        check("R8 stop released", sda_pull, 0);
        check("R8 fault held", fault, 1);
        check("R8 disc held", disc_req, 1);
        scl_hold = 1'b0; tick(1);
        check("R8 fault cleared", fault, 0);
        check("R8 disc cleared", disc_req, 0);
        settle();
    endtask

    task automatic t_early_release();
        sda_hold = 1'b1; tick(S + 1);
        check("R4 fault sda", fault, 1);
        tick(6 * H + 2);
        sda_hold = 1'b0; tick(1);
        check("R6 fault cleared", fault, 0);
        check("R6 clocking stopped", scl_pull, 0);
        check("R7 sda_pull", sda_pull, 1);
        tick(T - 1);
        check("R7 stop still held", sda_pull, 1);
        check("R7 scl released", scl_pull, 0);
        tick(1);
        check("R7 stop released", sda_pull, 0);
        check("R7 disc dropped", disc_req, 0);
        settle();
    endtask

    task automatic t_same_cycle(input bit late);
        sda_hold = 1'b1; tick(S + 1);
        tick(2 * H * P - 1 + (late ? 1 : 0));
        sda_hold = 1'b0;
        if (!late) begin
            tick(1);
            check("R11 release wins", fault, 0);
            check("R11 stop begun", sda_pull, 1);
            tick(T);
            check("R11 disc dropped", disc_req, 0);
        end else begin
            check("R11 late fault kept", fault, 1);
            check("R11 late stop", sda_pull, 1);
            tick(T);
            check("R11 late hold fault", fault, 1);
            tick(1);
            check("R11 late fault cleared", fault, 0);
        end
        settle();
    endtask

    task automatic t_enable();
        sda_hold = 1'b1; tick(S + 6);
        en = 1'b0; tick(1);
        check("R10 fault clear", fault, 0);
        check("R10 disc clear", disc_req, 0);
        check("R10 pulls clear", {scl_pull, sda_pull}, 0);
        check("R10 ready low", ready, 0);
        en = 1'b1; tick(S);
        check("R10 timer restarted", fault, 0);
        tick(1);
        check("R10 fault again", fault, 1);
        en = 1'b0; tick(1);
        settle();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_sda_manual();
        t_scl_exhaust();
        t_early_release();
        t_same_cycle(1'b0);
        t_same_cycle(1'b1);
        t_enable();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100_000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule